// File: doc/BRIEF.md
# Debounced Edge Interrupt Monitor

The monitor watches six slow board-level inputs: a power button, three keyboard lines, an AC-present indication and a shared reset line. For each input, a high-to-low edge and a low-to-high edge can be enabled separately, and both can be enabled at once. An enabled edge counts as an event only after the new level has stayed steady for a programmable number of clock cycles. That window is shared by all inputs.

An event sets a sticky status bit. There is one status bit per input per edge direction. Any set status bit raises a single combined interrupt. Software clears a status bit by writing 1 to its clear strobe. If a new event arrives in the same cycle as a clear, the event wins.

Each input has its own three-state machine:
- `ST_SEED` is the first cycle after reset. It takes the sampled level as the reference and moves to `ST_IDLE`.
- In `ST_IDLE`, the channel compares the input with the reference.
  - On a difference in an enabled direction, it takes transition *arm* into `ST_WAIT`.
  - On a difference in a disabled direction, it takes transition *follow*: it copies the new level into the reference and stays in `ST_IDLE`.
- In `ST_WAIT`, one of two transitions leads back to `ST_IDLE`:
  - *discard*: the input went back to the reference.
  - *fire*: the counter reached the debounce value. The channel then pulses its event and takes the new level as the reference.

Top module: `edge_irq_monitor`

## Requirements
- R1: After reset, `status_o` is 0 and `irq_o` is 0. The level each input has when reset ends is the reference, so it does not raise an event even when held at an enabled level.
- R2: Source i, for i from 0 to 5, changes to low and stays low, with its bit set in `fall_en_i`. Status bit 2i sets exactly D+2 clock edges after the change, where D is `debounce_cycles_i`. The low level must be present at D+2 consecutive sampling edges. This holds for D = 0 as well.
- R3: The same rule applies to a change from low to high with `rise_en_i[i]` set. It sets status bit 2i+1.
- R4: An edge whose direction is not enabled sets no status bit. The reference follows that edge, so the next opposite, enabled edge is still reported.
- R5: With both directions enabled for a source, a press followed by a release sets both bit 2i and bit 2i+1.
- R6: If the input goes back to its prior level before the debounce window has passed, the pending event is discarded and no status bit sets.
- R7: A status bit stays set until a cycle in which its `clear_i` bit is 1. That cycle clears it on the next edge. Clear bits that are 0 leave status unchanged.
- R8: `irq_o` is 1 exactly when at least one status bit is 1.
- R9: If an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: The source index order is fixed: 0 power button, 1 to 3 key lines 0 to 2, 4 AC present, 5 reset line. Each source uses the status bit pair {2i+1 rise, 2i fall}.
- R11: Sources are independent. Simultaneous edges on several sources each set their own bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_btn_i | input | 1 | Power button level (source 0) |
| key_i | input | 3 | Keyboard line levels (sources 1 to 3) |
| ac_present_i | input | 1 | AC-present level (source 4) |
| rst_line_i | input | 1 | Reset line level (source 5) |
| fall_en_i | input | 6 | Per-source high-to-low detection enable |
| rise_en_i | input | 6 | Per-source low-to-high detection enable |
| debounce_cycles_i | input | 16 | Shared debounce length D |
| clear_i | input | 12 | Write-1-to-clear strobes, one per status bit |
| status_o | output | 12 | Sticky event status, bit 2i fall and bit 2i+1 rise of source i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check on every cycle that:
- a fired event matches the input's current level and that level was steady on the previous edge;
- a set bit stays set until cleared, and a clear without a coinciding event empties it;
- a coinciding event keeps the bit set;
- the interrupt only rises after an event.

Only the bench scenarios can show:
- the exact D+2 latency at both a non-zero D and D = 0;
- that glitches are discarded;
- that disabled directions are followed silently;
- that the reference seeded at reset raises nothing;
- that the bit mapping across sources is correct.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int NUM_SRC  = 6;
    localparam int NUM_STAT = 2 * NUM_SRC;

    localparam int SRC_PWR  = 0;
    localparam int SRC_KEY0 = 1;
    localparam int SRC_AC   = 4;
    localparam int SRC_RST  = 5;

    typedef enum logic [1:0] {
        ST_SEED = 2'd0,
        ST_IDLE = 2'd1,
        ST_WAIT = 2'd2
    } dbc_state_e;

endpackage

// File: rtl/edge_dbc_channel.sv
module edge_dbc_channel
    import edge_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_i,
    input  logic             fall_en_i,
    input  logic             rise_en_i,
    input  logic [CNT_W-1:0] deb_i,
    output logic             evt_fall_o,
    output logic             evt_rise_o
);

    dbc_state_e       state_q, state_d;
    logic             ref_q, ref_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             differs;
    logic             dir_enabled;
    logic             fire;

    assign differs     = (sig_i != ref_q);
    assign dir_enabled = sig_i ? rise_en_i : fall_en_i;
    assign fire        = (state_q == ST_WAIT) && differs && (cnt_q >= deb_i);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEED;
            ref_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        ref_d   = ref_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SEED: begin
                ref_d   = sig_i;
                state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (differs) begin
                    if (dir_enabled) begin
                        state_d = ST_WAIT;       // arm
                        cnt_d   = '0;
                    end else begin
                        ref_d   = sig_i;         // follow
                    end
                end
            end
            ST_WAIT: begin
                if (!differs) begin
                    state_d = ST_IDLE;           // discard
                end else if (cnt_q >= deb_i) begin
                    state_d = ST_IDLE;           // fire
                    ref_d   = sig_i;
                end else begin
                    cnt_d   = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_SEED;
        endcase
    end

    // Output logic
    always_comb begin
        evt_fall_o = 1'b0;
        evt_rise_o = 1'b0;
        if (fire) begin
            evt_fall_o = !sig_i;
            evt_rise_o = sig_i;
        end
    end

    a_r2_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        evt_fall_o |-> !sig_i);
    a_r3_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rise_o |-> sig_i);
    a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_fall_o || evt_rise_o) |-> (sig_i == $past(sig_i)));
    a_r1_seed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED) |-> !(evt_fall_o || evt_rise_o));

endmodule

// File: rtl/edge_status_reg.sv
module edge_status_reg #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o,
    output logic             irq_o
);

    logic [WIDTH-1:0] stat_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          stat_q[b] <= 1'b0;
            else if (set_i[b])   stat_q[b] <= 1'b1;
            else if (clr_i[b])   stat_q[b] <= 1'b0;
        end

        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> stat_q[b]);
        a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[b] && !clr_i[b]) |=> stat_q[b]);
        a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set_i[b]) |=> !stat_q[b]);
    end

    assign status_o = stat_q;
    assign irq_o    = |stat_q;

    a_r8_irq_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|set_i));

endmodule

// File: rtl/edge_irq_monitor.sv
module edge_irq_monitor
    import edge_irq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_btn_i,
    input  logic [2:0]          key_i,
    input  logic                ac_present_i,
    input  logic                rst_line_i,
    input  logic [NUM_SRC-1:0]  fall_en_i,
    input  logic [NUM_SRC-1:0]  rise_en_i,
    input  logic [CNT_W-1:0]    debounce_cycles_i,
    input  logic [NUM_STAT-1:0] clear_i,
    output logic [NUM_STAT-1:0] status_o,
    output logic                irq_o
);

    logic [NUM_SRC-1:0]  src_lvl;
    logic [NUM_STAT-1:0] evt;

    // R10: source index order
    assign src_lvl = {rst_line_i, ac_present_i, key_i, pwr_btn_i};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        edge_dbc_channel #(.CNT_W(CNT_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sig_i      (src_lvl[s]),
            .fall_en_i  (fall_en_i[s]),
            .rise_en_i  (rise_en_i[s]),
            .deb_i      (debounce_cycles_i),
            .evt_fall_o (evt[2*s]),
            .evt_rise_o (evt[2*s+1])
        );
    end

    edge_status_reg #(.WIDTH(NUM_STAT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (evt),
        .clr_i    (clear_i),
        .status_o (status_o),
        .irq_o    (irq_o)
    );

endmodule

// File: tb/sim_edge_irq_monitor.sv
module sim_edge_irq_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr = 1'b1;
    logic [2:0]  key = 3'b111;
    logic        ac = 1'b0;
    logic        rline = 1'b0;
    logic [5:0]  fall_en = 6'h3f;
    logic [5:0]  rise_en = 6'h3f;
    logic [15:0] deb = 16'd3;
    logic [11:0] clr = '0;
    logic [11:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    edge_irq_monitor u0 (
        .clk(clk), .rst_n(rst_n), .pwr_btn_i(pwr), .key_i(key),
        .ac_present_i(ac), .rst_line_i(rline), .fall_en_i(fall_en),
        .rise_en_i(rise_en), .debounce_cycles_i(deb), .clear_i(clr),
        .status_o(status), .irq_o(irq)
    );

    task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        clr = 12'hfff;
        ticks(1);
        clr = '0;
        ticks(1);
    endtask

    task automatic t_reset();
        chk(status, 12'h000, "R1 status in reset");
        chk({11'd0, irq}, 12'h000, "R1 irq in reset");
        ticks(2);
        rst_n = 1'b1;
        ticks(10);
        chk(status, 12'h000, "R1 seeded reference raises nothing");
        chk({11'd0, irq}, 12'h000, "R1 irq quiet");
    endtask

    task automatic t_fall_timing();
        key[0] = 1'b0;
        ticks(int'(deb) + 1);
        chk(status, 12'h000, "R2 not before D+2 edges");
        ticks(1);
        chk(status, 12'h004, "R2 R10 key0 fall bit 2");
        chk({11'd0, irq}, 12'h001, "R8 irq raised");
        clr = 12'hffb;
        ticks(1);
        clr = '0;
        chk(status, 12'h004, "R7 zero clear bit keeps status");
        clr = 12'h004;
        ticks(1);
        clr = '0;
        chk(status, 12'h000, "R7 write-1 clears");
        chk({11'd0, irq}, 12'h000, "R8 irq drops");
    endtask

    task automatic t_rise();
        key[0] = 1'b1;
        ticks(int'(deb) + 2);
        chk(status, 12'h008, "R3 key0 rise bit 3");
        clear_all();
    endtask

    task automatic t_disabled();
        rise_en[2] = 1'b0;
        key[1] = 1'b0;
        ticks(int'(deb) + 2);
        chk(status, 12'h010, "R4 key1 fall set");
        clear_all();
        key[1] = 1'b1;
        ticks(20);
        chk(status, 12'h000, "R4 disabled rise ignored");
        key[1] = 1'b0;
        ticks(int'(deb) + 2);
        chk(status, 12'h010, "R4 reference followed, fall reported again");
        clear_all();
        key[1] = 1'b1;
        ticks(5);
        rise_en[2] = 1'b1;
    endtask

    task automatic t_glitch();
        key[2] = 1'b0;
        ticks(int'(deb) + 1);
        key[2] = 1'b1;
        ticks(20);
        chk(status, 12'h000, "R6 short glitch discarded");
    endtask

    task automatic t_both();
        pwr = 1'b0;
        ticks(int'(deb) + 2);
        chk(status, 12'h001, "R5 press sets bit 0");
        pwr = 1'b1;
        ticks(int'(deb) + 2);
        chk(status, 12'h003, "R5 release sets bit 1");
        clear_all();
    endtask

    task automatic t_set_wins();
        ac = 1'b1;
        ticks(int'(deb) + 1);
        clr = 12'hfff;
        ticks(1);
        clr = '0;
        chk(status, 12'h200, "R9 event beats clear");
        ticks(3);
        chk(status, 12'h200, "R7 bit stays set");
        clear_all();
        chk(status, 12'h000, "R7 cleared after");
    endtask

    task automatic t_d_zero();
        deb = 16'd0;
        rline = 1'b1;
        ticks(1);
        chk(status, 12'h000, "R3 D=0 not after one edge");
        ticks(1);
        chk(status, 12'h800, "R3 R10 D=0 reset line rise bit 11");
        clear_all();
        deb = 16'd3;
        ticks(2);
    endtask

    task automatic t_parallel();
        key[0] = 1'b0;
        key[2] = 1'b0;
        ticks(int'(deb) + 2);
        chk(status, 12'h044, "R11 simultaneous key0 and key2 falls");
        clear_all();
    endtask

    initial begin
        ticks(1);
        t_reset();
        t_fall_timing();
        t_rise();
        t_disabled();
        t_glitch();
        t_both();
        t_set_wins();
        t_d_zero();
        t_parallel();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule